// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller collects four classes of interrupt request and presents the most urgent one to a processor core. The classes have fixed priorities. Hardware failure (machine check) is the most urgent. Program errors come next; the core signals these with a one-cycle pulse, for example on a division by zero. A periodic timer follows, and input/output requests are the least urgent. Each request is latched into a sticky pending register. The controller raises a single interrupt line while an eligible request is pending.

When the core acknowledges, the controller does four things. It reports the index of the chosen source. It forms a vector address by adding that source's 8-bit offset to a programmable table base; the core loads this address into its program counter. It clears the pending bit of that source. It pushes the source's level onto a small in-service stack. While a level is in service, only strictly more urgent requests can raise the interrupt line, so service routines nest. An end-of-service strobe pops the stack, which restores the previous mask. A built-in down-counter with a programmable period raises the timer request.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_o, vector_valid_o, ack_src_o and vector_o are all 0. No request is pending, the in-service stack is empty, the timer is stopped, and the table base equals parameter BASE_RST.
- R2: A one-cycle high on mchk_i, pchk_i or io_i sets that source's pending bit at the next clock edge. The bit stays set until the source is accepted. If a request arrives in the same cycle as the clearing acknowledge, the request wins.
- R3: Source indices are 0 for machine check, 1 for program check, 2 for timer and 3 for I/O. A lower index means higher priority. Among the eligible pending sources, the one with the lowest index is selected.
- R4: An acknowledge (ack_i high while irq_o is high) is accepted at the clock edge. From the next cycle, ack_src_o holds the selected index and vector_o holds base + zero-extended src_offset_i[8*idx+7 : 8*idx]. vector_valid_o is high for the single cycle after each accepted acknowledge, and the selected pending bit is cleared.
- R5: ack_i while irq_o is low is ignored. vector_valid_o stays low, and ack_src_o and vector_o are unchanged.
- R6: While any level is in service, only pending sources with a lower index than the most recently accepted level can assert irq_o. Requests of equal or lower priority stay pending.
- R7: eos_i pops the most recent in-service level and restores the mask of the level below it. eos_i is ignored when the stack is empty, and also in a cycle where an acknowledge is accepted.
- R8: base_we_i loads base_wdata_i into the table base at the clock edge. Every vector formed afterwards uses the new base.
- R9: Writing a nonzero period P with period_we_i makes the timer request pending P clock edges after the write edge, and again every P edges after that. Writing P = 0 stops the timer.
- R10: The vector sum is taken modulo 2^16, so a carry out of the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mchk_i | input | 1 | Machine check request (index 0) |
| pchk_i | input | 1 | Program check pulse (index 1) |
| io_i | input | 1 | I/O request (index 3) |
| src_offset_i | input | 32 | Per-source vector offsets, 8 bits each, source idx at bits 8*idx+7 : 8*idx |
| base_we_i | input | 1 | Table base write enable |
| base_wdata_i | input | 16 | Table base write data |
| period_we_i | input | 1 | Timer period write enable |
| period_wdata_i | input | 16 | Timer period write data (0 stops the timer) |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| eos_i | input | 1 | End of service strobe |
| irq_o | output | 1 | Interrupt request to the core |
| ack_src_o | output | 2 | Index of the last accepted source |
| vector_o | output | 16 | Vector address of the last accepted source |
| vector_valid_o | output | 1 | One-cycle strobe after an accepted acknowledge |

## Verification
The bench keeps the default widths and a stack depth of four, equal to the number of sources. It overrides BASE_RST to 16'hFFF0. With that base, the wrap-around of the vector sum (an I/O offset of 8'h20 gives 16'h0010) is reached straight from reset, without a base write first. Later, a base write to 16'h1000 shows that newly formed vectors follow the written base. The tests cover two-level nesting, end-of-service on an empty stack, and an acknowledge in the same cycle as an end-of-service strobe. A five-cycle timer period makes the exact tick spacing observable on irq_o.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned NSRC  = 4;
   localparam int unsigned LVL_W = $clog2(NSRC);

   typedef enum logic [LVL_W-1:0] {
      SRC_MCHK = 2'd0,
      SRC_PCHK = 2'd1,
      SRC_TMR  = 2'd2,
      SRC_IO   = 2'd3
   } src_e;

   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/intc_timer.sv
module intc_timer #(
   parameter int unsigned TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_we_i,
   input  logic [TMR_W-1:0] period_i,
   output logic             tick_o
);
   logic [TMR_W-1:0] period_q;
   logic [TMR_W-1:0] cnt_q;
   logic             run;
   logic             at_end;

   assign run    = (period_q != '0);
   assign at_end = (cnt_q <= TMR_W'(1));
   assign tick_o = run && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         cnt_q    <= '0;
      end else if (period_we_i) begin
         period_q <= period_i;
         cnt_q    <= period_i;
      end else if (run) begin
         cnt_q <= at_end ? period_q : cnt_q - TMR_W'(1);
      end
   end
endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel
   import intc_pkg::*;
(
   input  logic [NSRC-1:0] pend_i,
   input  logic            busy_i,
   input  lvl_t            top_i,
   output logic            irq_o,
   output lvl_t            sel_o
);
   logic [NSRC-1:0] elig;

   for (genvar g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = pend_i[g] && (!busy_i || (LVL_W'(g) < top_i));
   end

   assign irq_o = |elig;

   always_comb begin
      sel_o = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i]) sel_o = LVL_W'(i);
      end
   end
endmodule

// File: rtl/intc_svc_stack.sv
module intc_svc_stack
   import intc_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned SPW  = $clog2(DEPTH + 1),
   localparam int unsigned IDXW = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_i,
   input  lvl_t           lvl_i,
   input  logic           pop_i,
   output logic           busy_o,
   output lvl_t           top_o,
   output logic [SPW-1:0] depth_o
);
   lvl_t           stk_q [DEPTH];
   logic [SPW-1:0] sp_q;
   logic [IDXW-1:0] wr_idx;
   logic [IDXW-1:0] rd_idx;

   assign wr_idx  = IDXW'(sp_q);
   assign rd_idx  = IDXW'(sp_q - SPW'(1));
   assign busy_o  = (sp_q != '0);
   assign top_o   = busy_o ? stk_q[rd_idx] : '0;
   assign depth_o = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
      end else if (push_i && (sp_q < SPW'(DEPTH))) begin
         stk_q[wr_idx] <= lvl_i;
         sp_q          <= sp_q + SPW'(1);
      end else if (pop_i && busy_o) begin
         sp_q <= sp_q - SPW'(1);
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned TMR_W    = 16,
   parameter int unsigned DEPTH    = 4,
   parameter logic [ADDR_W-1:0] BASE_RST = '0,
   localparam int unsigned SPW     = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mchk_i,
   input  logic                   pchk_i,
   input  logic                   io_i,
   input  logic [NSRC*OFS_W-1:0]  src_offset_i,
   input  logic                   base_we_i,
   input  logic [ADDR_W-1:0]      base_wdata_i,
   input  logic                   period_we_i,
   input  logic [TMR_W-1:0]       period_wdata_i,
   input  logic                   ack_i,
   input  logic                   eos_i,
   output logic                   irq_o,
   output logic [LVL_W-1:0]       ack_src_o,
   output logic [ADDR_W-1:0]      vector_o,
   output logic                   vector_valid_o
);
   if (DEPTH < NSRC) begin : g_bad_depth
      $error("DEPTH must cover one entry per source class");
   end
   if (OFS_W > ADDR_W) begin : g_bad_ofs
      $error("OFS_W must not exceed ADDR_W");
   end

   logic [NSRC-1:0]  pend_q;
   logic [NSRC-1:0]  set_v;
   logic [NSRC-1:0]  clr_v;
   logic [ADDR_W-1:0] base_q;
   logic             tmr_tick;
   logic             accept;
   lvl_t             sel;
   logic             svc_busy;
   lvl_t             svc_top;
   logic [SPW-1:0]   svc_depth;
   logic [OFS_W-1:0] ofs_arr [NSRC];
   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] vec_sum;

   intc_timer #(.TMR_W(TMR_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_we_i (period_we_i),
      .period_i    (period_wdata_i),
      .tick_o      (tmr_tick)
   );

   intc_prio_sel u_sel (
      .pend_i (pend_q),
      .busy_i (svc_busy),
      .top_i  (svc_top),
      .irq_o  (irq_o),
      .sel_o  (sel)
   );

   intc_svc_stack #(.DEPTH(DEPTH)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (accept),
      .lvl_i   (sel),
      .pop_i   (eos_i && !accept),
      .busy_o  (svc_busy),
      .top_o   (svc_top),
      .depth_o (svc_depth)
   );

   for (genvar g = 0; g < NSRC; g++) begin : g_ofs
      assign ofs_arr[g] = src_offset_i[g*OFS_W +: OFS_W];
   end

   if (OFS_W == ADDR_W) begin : g_ofs_full
      assign ofs_ext = ofs_arr[sel];
   end else begin : g_ofs_zext
      assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, ofs_arr[sel]};
   end

   assign vec_sum = base_q + ofs_ext;
   assign accept  = ack_i && irq_o;

   always_comb begin
      set_v           = '0;
      set_v[SRC_MCHK] = mchk_i;
      set_v[SRC_PCHK] = pchk_i;
      set_v[SRC_TMR]  = tmr_tick;
      set_v[SRC_IO]   = io_i;
      clr_v           = '0;
      if (accept) clr_v[sel] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q         <= '0;
         base_q         <= BASE_RST;
         ack_src_o      <= '0;
         vector_o       <= '0;
         vector_valid_o <= 1'b0;
      end else begin
         pend_q         <= (pend_q & ~clr_v) | set_v;
         vector_valid_o <= accept;
         if (base_we_i) base_q <= base_wdata_i;
         if (accept) begin
            ack_src_o <= sel;
            vector_o  <= vec_sum;
         end
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFS_W  = 8,
   parameter int unsigned SPW    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  irq_o,
   input logic                  ack_i,
   input logic                  eos_i,
   input logic                  vector_valid_o,
   input logic [ADDR_W-1:0]     vector_o,
   input logic [LVL_W-1:0]      ack_src_o,
   input logic [ADDR_W-1:0]     base_q,
   input logic [NSRC*OFS_W-1:0] src_offset_i,
   input logic [NSRC-1:0]       pend_q,
   input logic                  svc_busy,
   input logic [LVL_W-1:0]      svc_top,
   input logic [SPW-1:0]        svc_depth
);
   logic [ADDR_W-1:0]     base_d;
   logic [NSRC*OFS_W-1:0] ofs_d;

   always_ff @(posedge clk) begin
      base_d <= base_q;
      ofs_d  <= src_offset_i;
   end

   AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vector_valid_o |-> $past(ack_i && irq_o)); // R4
   AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o) |=> !vector_valid_o); // R5
   AST_VEC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      vector_valid_o |-> (vector_o == ADDR_W'(base_d + ADDR_W'(ofs_d[ack_src_o*OFS_W +: OFS_W])))); // R10
   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_q != '0)); // R2
   AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      (vector_valid_o && $past(svc_busy)) |-> (ack_src_o < $past(svc_top))); // R6
   AST_POP_ON_EOS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eos_i) && !$past(ack_i && irq_o) && ($past(svc_depth) != '0))
         |-> (svc_depth == $past(svc_depth) - SPW'(1))); // R7
   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      svc_depth <= SPW'(NSRC)); // R6
endmodule

bind prio_vec_intc intc_chk #(
   .ADDR_W(ADDR_W),
   .OFS_W (OFS_W),
   .SPW   (SPW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .irq_o          (irq_o),
   .ack_i          (ack_i),
   .eos_i          (eos_i),
   .vector_valid_o (vector_valid_o),
   .vector_o       (vector_o),
   .ack_src_o      (ack_src_o),
   .base_q         (base_q),
   .src_offset_i   (src_offset_i),
   .pend_q         (pend_q),
   .svc_busy       (svc_busy),
   .svc_top        (svc_top),
   .svc_depth      (svc_depth)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mchk_i = 1'b0, pchk_i = 1'b0, io_i = 1'b0;
   logic [31:0] src_offset_i = {8'h20, 8'h0C, 8'h08, 8'h04};
   logic        base_we_i = 1'b0;
   logic [15:0] base_wdata_i = '0;
   logic        period_we_i = 1'b0;
   logic [15:0] period_wdata_i = '0;
   logic        ack_i = 1'b0, eos_i = 1'b0;
   logic        irq_o;
   logic [1:0]  ack_src_o;
   logic [15:0] vector_o;
   logic        vector_valid_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_vec_intc #(.BASE_RST(16'hFFF0)) u_dut (
      .clk(clk), .rst_n(rst_n), .mchk_i(mchk_i), .pchk_i(pchk_i), .io_i(io_i),
      .src_offset_i(src_offset_i), .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
      .period_we_i(period_we_i), .period_wdata_i(period_wdata_i),
      .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .ack_src_o(ack_src_o),
      .vector_o(vector_o), .vector_valid_o(vector_valid_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic pulse(input logic m, input logic p, input logic i);
      mchk_i = m; pchk_i = p; io_i = i;
      nxt();
      mchk_i = 0; pchk_i = 0; io_i = 0;
   endtask

   task automatic do_ack();
      ack_i = 1; nxt(); ack_i = 0;
   endtask

   task automatic do_eos();
      eos_i = 1; nxt(); eos_i = 0;
   endtask

   task automatic expect_vec(input string req, input int src, input int vec);
      check(req, "vector_valid_o", int'(vector_valid_o), 1);
      check(req, "ack_src_o", int'(ack_src_o), src);
      check(req, "vector_o", int'(vector_o), vec);
   endtask

   task automatic t_reset();
      check("R1", "irq_o", int'(irq_o), 0);
      check("R1", "vector_valid_o", int'(vector_valid_o), 0);
      check("R1", "ack_src_o", int'(ack_src_o), 0);
      check("R1", "vector_o", int'(vector_o), 0);
   endtask

   task automatic t_io_wrap();
      pulse(0, 0, 1);
      check("R2", "irq after io pulse", int'(irq_o), 1);
      nxt();
      check("R2", "irq sticky", int'(irq_o), 1);
      do_ack();
      expect_vec("R10", 3, 16'h0010);
      check("R4", "irq after ack", int'(irq_o), 0);
      nxt();
      check("R4", "valid one cycle", int'(vector_valid_o), 0);
      do_eos();
   endtask

   task automatic t_nesting();
      pulse(0, 1, 1);
      check("R3", "irq", int'(irq_o), 1);
      do_ack();
      expect_vec("R3", 1, 16'hFFF8);
      check("R6", "io masked by level 1", int'(irq_o), 0);
      pulse(0, 1, 0);
      check("R6", "equal level masked", int'(irq_o), 0);
      pulse(1, 0, 0);
      check("R6", "higher level passes", int'(irq_o), 1);
      do_ack();
      expect_vec("R6", 0, 16'hFFF4);
      do_eos();
      check("R7", "mask of level 1 restored", int'(irq_o), 0);
      do_eos();
      check("R7", "stack empty, irq", int'(irq_o), 1);
      do_ack();
      expect_vec("R3", 1, 16'hFFF8);
      do_eos();
      do_ack();
      expect_vec("R3", 3, 16'h0010);
      do_eos();
      check("R2", "nothing left pending", int'(irq_o), 0);
   endtask

   task automatic t_ack_idle();
      do_ack();
      check("R5", "valid on idle ack", int'(vector_valid_o), 0);
      check("R5", "src unchanged", int'(ack_src_o), 3);
      check("R5", "vector unchanged", int'(vector_o), 16'h0010);
   endtask

   task automatic t_eos_empty();
      do_eos();
      do_eos();
      pulse(0, 0, 1);
      check("R7", "eos on empty stack ignored", int'(irq_o), 1);
      do_ack();
      expect_vec("R7", 3, 16'h0010);
      do_eos();
   endtask

   task automatic t_ack_eos();
      pulse(0, 1, 0);
      do_ack();
      expect_vec("R7", 1, 16'hFFF8);
      pulse(1, 0, 0);
      ack_i = 1; eos_i = 1; nxt(); ack_i = 0; eos_i = 0;
      expect_vec("R7", 0, 16'hFFF4);
      pulse(0, 0, 1);
      check("R7", "io masked at depth 2", int'(irq_o), 0);
      do_eos();
      check("R7", "level 1 still in service", int'(irq_o), 0);
      do_eos();
      check("R7", "stack empty after two pops", int'(irq_o), 1);
      do_ack();
      do_eos();
   endtask

   task automatic t_base();
      base_we_i = 1; base_wdata_i = 16'h1000; nxt(); base_we_i = 0;
      pulse(0, 1, 0);
      do_ack();
      expect_vec("R8", 1, 16'h1008);
      do_eos();
   endtask

   task automatic t_timer();
      bit quiet = 1;
      period_we_i = 1; period_wdata_i = 16'd5; nxt(); period_we_i = 0;
      for (int k = 1; k <= 4; k++) begin
         nxt();
         check("R9", $sformatf("no tick %0d edges after write", k), int'(irq_o), 0);
      end
      nxt();
      check("R9", "tick after 5 edges", int'(irq_o), 1);
      do_ack();
      expect_vec("R9", 2, 16'h100C);
      do_eos();
      nxt();
      check("R9", "no tick 8 edges", int'(irq_o), 0);
      nxt();
      check("R9", "no tick 9 edges", int'(irq_o), 0);
      nxt();
      check("R9", "second tick at 10 edges", int'(irq_o), 1);
      period_we_i = 1; period_wdata_i = 16'd0; ack_i = 1;
      nxt();
      period_we_i = 0; ack_i = 0;
      expect_vec("R9", 2, 16'h100C);
      do_eos();
      for (int k = 0; k < 20; k++) begin
         nxt();
         if (irq_o) quiet = 0;
      end
      check("R9", "timer stopped by zero period", int'(quiet), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) nxt();
      rst_n = 1;
      nxt();
      t_reset();
      t_io_wrap();
      t_nesting();
      t_ack_idle();
      t_eos_empty();
      t_ack_eos();
      t_base();
      t_timer();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule